// File: doc/BRIEF.md
# Debug Break and Protection Comparator Group

This block holds two address/data comparators that watch a fetch bus and an operand bus every cycle. In break mode each comparator tests its selected input for equality with a programmed value. A hit sets a pair of sticky detect flags and pulses a break request. The two comparators can act independently, or together as one combined address-and-data breakpoint.

When the protection bit is set, the same two comparator values instead bound a single address range. The lower bound is included and the upper bound is excluded. Each access that the selected type code covers is checked against that range, using the read, write and execute permissions for the current privilege level. An access that falls outside the range, or lacks a needed permission, pulses a fault output one cycle later. Software programs the group through a four-entry register port and clears detect flags by writing ones to them.

Top module: `dbg_cmp_group`

Register map (reg_addr):

- 0: comparator side 0 value.
- 1: comparator side 1 value.
- 2: control word.
- 3: detect flags. Reading returns the flags. Writing a 1 to a bit clears that bit.

Control word bits:

| Bits | Field |
|------|-------|
| [1:0] | Type code |
| [3:2] | Enable field A (gates side 1) |
| [5:4] | Enable field B (gates side 0) |
| 6 | Combine |
| 7 | Protection enable |
| 8 | User read |
| 9 | User write |
| 10 | User execute |
| 11 | Supervisor read |
| 12 | Supervisor write |
| 13 | Supervisor execute |

## Requirements
- R1: After reset the control word (reg_addr 2) and the flags (reg_addr 3) read 0, and brk_req and prot_fault are 0.
- R2: The type code selects each side's input. With code 00 both sides take the fetch address. With code 01 both sides take the operand address. With code 10, side 1 takes the operand address and side 0 the fetch address. With code 11, side 1 takes the operand address and side 0 the operand data. A side matches only in a cycle in which its source bus is valid.
- R3: With combine 0 and protection 0, the two sides break independently. A side-1 match with enable field A nonzero sets flags 1 and 3. A side-0 match with enable field B nonzero sets flags 0 and 2. With both fields zero, nothing is detected.
- R4: With combine 1 and protection 0, flags 0 and 2 are set only when both enable fields are nonzero and both sides match in the same cycle. Every other case sets nothing.
- R5: brk_req pulses for one cycle, in the cycle after any flag-setting access. Flags stay set until software writes a 1 to them at reg_addr 3. Bits written as 0 are unaffected.
- R6: With protection 1, an access is inside the range when side0 <= address < side1. A covered access outside the range raises prot_fault.
- R7: The permission bits used are the supervisor bits when sup_mode is 1 and the user bits otherwise. A fetch needs execute, a read needs read, and a write needs write. Type 00 covers only fetches, type 01 covers only operand accesses, and type 10 covers both.
- R8: A read-modify-write access (op_rmw) needs both the read and the write permission.
- R9: With protection 1 and type 11, no access raises prot_fault.
- R10: While protection is 1, no break flag is set and brk_req stays 0.
- R11: prot_fault is 0 in the cycle of the offending access, is 1 in the cycle after it, and returns to 0 after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch address valid this cycle |
| fetch_addr | input | W | Instruction fetch address |
| op_rd | input | 1 | Operand read |
| op_wr | input | 1 | Operand write |
| op_rmw | input | 1 | Operand read-modify-write |
| op_addr | input | W | Operand address |
| op_data | input | W | Operand data value |
| sup_mode | input | 1 | 1 = supervisor, 0 = user |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| brk_req | output | 1 | Break request pulse |
| brk_flags | output | 4 | Sticky detect flags |
| prot_fault | output | 1 | Protection fault pulse |

## Verification
The break sweep runs every type code with each enable pattern and both combine settings. The fetch address, operand address and data each take the side-0 value, the side-1 value or a non-matching value, under all four combinations of bus validity. This separates a wrong input selection from a wrong enable or combine rule, because each mistake sets a different flag pair. The protection sweep runs all 64 permission settings under every type code and both privilege levels. It uses addresses just below, at, inside, at and above the bounds, and fetch, read, write, read-modify-write and idle accesses. This exposes off-by-one bounds, swapped privilege banks, a missing read-modify-write rule and leakage in type 11. Directed tests cover the partial write-one-to-clear and the one-cycle fault timing.

// File: rtl/dbg_cmp_pkg.sv
// Shared types for the comparator group: type code encoding, control word
// layout and register indices. Assumes the register width is at least CTRL_W.
package dbg_cmp_pkg;
    typedef enum logic [1:0] {
        CT_IA_IA = 2'b00,
        CT_OA_OA = 2'b01,
        CT_OA_IA = 2'b10,
        CT_OA_DT = 2'b11
    } cmp_type_e;

    // Packed MSB first: bit 13 sx down to bits 1:0 ctype.
    typedef struct packed {
        logic      sx;
        logic      sw;
        logic      sr;
        logic      ux;
        logic      uw;
        logic      ur;
        logic      prot;
        logic      comb;
        logic [1:0] en_b;
        logic [1:0] en_a;
        cmp_type_e ctype;
    } ctrl_t;

    localparam int CTRL_W    = 14;
    localparam int FLAG_W    = 4;
    localparam int RA_CMP0   = 0;
    localparam int RA_CMP1   = 1;
    localparam int RA_CTRL   = 2;
    localparam int RA_STAT   = 3;
endpackage

// File: rtl/dbg_cmp_regs.sv
// Register file: two comparator values, the control word and the sticky
// detect flags. Flags are set by the evaluator and cleared by writing ones;
// a set in the same cycle as a clear wins. Assumes W >= CTRL_W.
module dbg_cmp_regs
    import dbg_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [W-1:0]      reg_wdata,
    input  logic [FLAG_W-1:0] set_flags,
    output logic [W-1:0]      reg_rdata,
    output ctrl_t             ctrl,
    output logic [W-1:0]      cmp0,
    output logic [W-1:0]      cmp1,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] clr_mask;

    // Clear mask from a write to the status register.
    always_comb begin
        clr_mask = '0;
        if (reg_wr && reg_addr == 2'(RA_STAT))
            clr_mask = reg_wdata[FLAG_W-1:0];
    end

    // Configuration and flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp0  <= '0;
            cmp1  <= '0;
            ctrl  <= '0;
            flags <= '0;
        end else begin
            if (reg_wr && reg_addr == 2'(RA_CMP0)) cmp0 <= reg_wdata;
            if (reg_wr && reg_addr == 2'(RA_CMP1)) cmp1 <= reg_wdata;
            if (reg_wr && reg_addr == 2'(RA_CTRL)) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            flags <= (flags & ~clr_mask) | set_flags;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            2'(RA_CMP0): reg_rdata = cmp0;
            2'(RA_CMP1): reg_rdata = cmp1;
            2'(RA_CTRL): reg_rdata = W'(ctrl);
            default:     reg_rdata = W'(flags);
        endcase
    end
endmodule

// File: rtl/dbg_cmp_match.sv
// Comparator datapath: selects each side's input from the type code, tests
// equality per side (qualified by source validity) and tests the fetch and
// operand addresses against the range [cmp0, cmp1).
module dbg_cmp_match
    import dbg_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  cmp_type_e    ctype,
    input  logic [W-1:0] ia,
    input  logic [W-1:0] oa,
    input  logic [W-1:0] dt,
    input  logic         fetch_v,
    input  logic         op_v,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    output logic [1:0]   hit,
    output logic         in_rng_i,
    output logic         in_rng_o
);
    logic [W-1:0] side_in [2];
    logic [1:0]   side_v;
    logic [W-1:0] side_ref [2];

    // Per-side input selection from the type code.
    always_comb begin
        case (ctype)
            CT_IA_IA: begin side_in[0] = ia; side_v[0] = fetch_v; end
            CT_OA_OA: begin side_in[0] = oa; side_v[0] = op_v;    end
            CT_OA_IA: begin side_in[0] = ia; side_v[0] = fetch_v; end
            default:  begin side_in[0] = dt; side_v[0] = op_v;    end
        endcase
        if (ctype == CT_IA_IA) begin
            side_in[1] = ia; side_v[1] = fetch_v;
        end else begin
            side_in[1] = oa; side_v[1] = op_v;
        end
        side_ref[0] = cmp0;
        side_ref[1] = cmp1;
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        assign hit[s] = side_v[s] && (side_in[s] == side_ref[s]);
    end

    assign in_rng_i = (ia >= cmp0) && (ia < cmp1);
    assign in_rng_o = (oa >= cmp0) && (oa < cmp1);
endmodule

// File: rtl/dbg_cmp_eval.sv
// Decision logic: turns comparator hits into flag-set requests (independent
// or combined) and range results into a permission fault. Break request and
// fault are registered, one cycle after the access.
module dbg_cmp_eval
    import dbg_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [1:0]        hit,
    input  logic              in_rng_i,
    input  logic              in_rng_o,
    input  logic              fetch_v,
    input  logic              op_rd,
    input  logic              op_wr,
    input  logic              op_rmw,
    input  logic              sup,
    output logic [FLAG_W-1:0] set_flags,
    output logic              brk_req,
    output logic              prot_fault
);
    logic ena, enb, pr, pw, px, need_r, need_w, op_v, chk_i, chk_o, fault_d;

    // Break flag requests from the hits.
    always_comb begin
        ena = |ctrl.en_a;
        enb = |ctrl.en_b;
        set_flags = '0;
        if (!ctrl.prot) begin
            if (ctrl.comb) begin
                if (ena && enb && hit[0] && hit[1]) set_flags = 4'b0101;
            end else begin
                if (enb && hit[0]) set_flags[0] = 1'b1;
                if (enb && hit[0]) set_flags[2] = 1'b1;
                if (ena && hit[1]) set_flags[1] = 1'b1;
                if (ena && hit[1]) set_flags[3] = 1'b1;
            end
        end
    end

    // Permission check against the range for the current privilege.
    always_comb begin
        pr     = sup ? ctrl.sr : ctrl.ur;
        pw     = sup ? ctrl.sw : ctrl.uw;
        px     = sup ? ctrl.sx : ctrl.ux;
        need_r = op_rd | op_rmw;
        need_w = op_wr | op_rmw;
        op_v   = op_rd | op_wr | op_rmw;
        chk_i  = (ctrl.ctype == CT_IA_IA) || (ctrl.ctype == CT_OA_IA);
        chk_o  = (ctrl.ctype == CT_OA_OA) || (ctrl.ctype == CT_OA_IA);
        fault_d = ctrl.prot &&
                  ((chk_i && fetch_v && !(in_rng_i && px)) ||
                   (chk_o && op_v && !(in_rng_o && (!need_r || pr) && (!need_w || pw))));
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req    <= 1'b0;
            prot_fault <= 1'b0;
        end else begin
            brk_req    <= |set_flags;
            prot_fault <= fault_d;
        end
    end
endmodule

// File: rtl/dbg_cmp_group.sv
// Top of the comparator group: register file, comparator datapath and
// decision logic. One group, one range; no arbitration with other groups.
module dbg_cmp_group
    import dbg_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [W-1:0]      fetch_addr,
    input  logic              op_rd,
    input  logic              op_wr,
    input  logic              op_rmw,
    input  logic [W-1:0]      op_addr,
    input  logic [W-1:0]      op_data,
    input  logic              sup_mode,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              brk_req,
    output logic [FLAG_W-1:0] brk_flags,
    output logic              prot_fault
);
    ctrl_t             ctrl;
    logic [W-1:0]      cmp0, cmp1;
    logic [FLAG_W-1:0] set_flags;
    logic [1:0]        hit;
    logic              in_rng_i, in_rng_o;
    logic              prot_en;
    logic [1:0]        cmp_type;

    assign prot_en  = ctrl.prot;
    assign cmp_type = ctrl.ctype;

    dbg_cmp_regs #(.W(W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .set_flags(set_flags), .reg_rdata(reg_rdata),
        .ctrl(ctrl), .cmp0(cmp0), .cmp1(cmp1), .flags(brk_flags)
    );

    dbg_cmp_match #(.W(W)) i_match (
        .ctype(ctrl.ctype), .ia(fetch_addr), .oa(op_addr), .dt(op_data),
        .fetch_v(fetch_valid), .op_v(op_rd | op_wr | op_rmw),
        .cmp0(cmp0), .cmp1(cmp1), .hit(hit),
        .in_rng_i(in_rng_i), .in_rng_o(in_rng_o)
    );

    dbg_cmp_eval i_eval (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .hit(hit),
        .in_rng_i(in_rng_i), .in_rng_o(in_rng_o), .fetch_v(fetch_valid),
        .op_rd(op_rd), .op_wr(op_wr), .op_rmw(op_rmw), .sup(sup_mode),
        .set_flags(set_flags), .brk_req(brk_req), .prot_fault(prot_fault)
    );
endmodule

// File: rtl/dbg_cmp_chk.sv
// Checker for the comparator group: timing, stickiness and mode exclusion
// properties over the top-level ports and the decoded control fields.
module dbg_cmp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_valid,
    input logic       op_rd,
    input logic       op_wr,
    input logic       op_rmw,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       brk_req,
    input logic [3:0] brk_flags,
    input logic       prot_fault,
    input logic       prot_en,
    input logic [1:0] cmp_type
);
    // R5: a break request always comes with a set flag.
    p_brk_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (brk_flags != 4'b0));

    // R5: without a status write, no flag falls.
    p_flags_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr && reg_addr == 2'd3) |-> ((brk_flags & $past(brk_flags)) == $past(brk_flags)));

    // R10: protection mode gives no break request.
    p_no_brk_in_prot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prot_en) |-> !brk_req);

    // R9: type 11 with protection never faults.
    p_type11_no_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prot_en && cmp_type == 2'b11) |-> !prot_fault);

    // R11: an idle cycle yields no output pulse in the next cycle.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!fetch_valid && !op_rd && !op_wr && !op_rmw) |-> (!brk_req && !prot_fault));

    // R6: fault only with protection enabled.
    p_fault_needs_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prot_en) |-> !prot_fault);
endmodule

bind dbg_cmp_group dbg_cmp_chk i_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .op_rd(op_rd),
    .op_wr(op_wr), .op_rmw(op_rmw), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .brk_req(brk_req), .brk_flags(brk_flags), .prot_fault(prot_fault),
    .prot_en(prot_en), .cmp_type(cmp_type)
);

// File: tb/test_dbg_cmp_group.sv
// Self-checking bench: sweeps of break and protection modes with expected
// values computed from the requirements.
module test_dbg_cmp_group;
    localparam int W = 16;
    localparam logic [15:0] LO = 16'h0100;
    localparam logic [15:0] HI = 16'h0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_valid = 1'b0, op_rd = 1'b0, op_wr = 1'b0, op_rmw = 1'b0, sup_mode = 1'b0;
    logic [W-1:0] fetch_addr = '0, op_addr = '0, op_data = '0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic brk_req, prot_fault;
    logic [3:0] brk_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_cmp_group #(.W(W)) i_dbg_cmp_group (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .op_rd(op_rd), .op_wr(op_wr), .op_rmw(op_rmw), .op_addr(op_addr),
        .op_data(op_data), .sup_mode(sup_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_req(brk_req),
        .brk_flags(brk_flags), .prot_fault(prot_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3; reg_wdata = '0;
    endtask

    // Drive one access for one cycle; returns at the negedge after the edge.
    task automatic access(input bit fv, input logic [W-1:0] ia, input bit rd, input bit wr,
                          input bit rmw, input logic [W-1:0] oa, input logic [W-1:0] dt,
                          input bit sup);
        @(negedge clk);
        fetch_valid = fv; fetch_addr = ia; op_rd = rd; op_wr = wr; op_rmw = rmw;
        op_addr = oa; op_data = dt; sup_mode = sup;
        @(negedge clk);
        fetch_valid = 1'b0; op_rd = 1'b0; op_wr = 1'b0; op_rmw = 1'b0;
    endtask

    function automatic logic [3:0] exp_brk(int t, int ea, int eb, bit cb, bit fv, bit ov,
                                           logic [15:0] ia, logic [15:0] oa, logic [15:0] dt);
        logic [15:0] s0, s1;
        bit v0, v1, m0, m1;
        logic [3:0] r;
        s0 = (t == 0 || t == 2) ? ia : (t == 1) ? oa : dt;
        v0 = (t == 0 || t == 2) ? fv : ov;
        s1 = (t == 0) ? ia : oa;
        v1 = (t == 0) ? fv : ov;
        m0 = v0 && (s0 == LO);
        m1 = v1 && (s1 == HI);
        r = 4'b0;
        if (cb) begin
            if (ea != 0 && eb != 0 && m0 && m1) r = 4'b0101;
        end else begin
            if (eb != 0 && m0) r = r | 4'b0101;
            if (ea != 0 && m1) r = r | 4'b1010;
        end
        return r;
    endfunction

    function automatic bit exp_fault(int t, int p, int k, bit sup, logic [15:0] a);
        bit inr, pr, pw, px;
        inr = (a >= LO) && (a < HI);
        pr = sup ? p[3] : p[0];
        pw = sup ? p[4] : p[1];
        px = sup ? p[5] : p[2];
        if (t == 3 || k == 4) return 1'b0;
        if (k == 0) return (t == 0 || t == 2) && !(inr && px);
        return (t == 1 || t == 2) && !(inr && (k == 2 || pr) && (k == 1 || pw));
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] vals [3];
        vals[0] = LO; vals[1] = HI; vals[2] = 16'h0300;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 brk_req", brk_req, 0);
        check("R1 prot_fault", prot_fault, 0);
        reg_addr = 2'd2; #1;
        check("R1 ctrl", reg_rdata, 0);
        reg_addr = 2'd3; #1;
        check("R1 flags", reg_rdata, 0);

        wr_reg(2'd0, LO);
        wr_reg(2'd1, HI);

        // R2 R3 R4: break sweep
        for (int t = 0; t < 4; t++)
        for (int ea = 0; ea < 2; ea++)
        for (int eb = 0; eb < 2; eb++)
        for (int cb = 0; cb < 2; cb++) begin
            wr_reg(2'd2, W'((cb << 6) | ((eb ? 1 : 0) << 4) | ((ea ? 2 : 0) << 2) | t));
            for (int vv = 0; vv < 4; vv++)
            for (int i = 0; i < 3; i++)
            for (int o = 0; o < 3; o++)
            for (int d = 0; d < 3; d++) begin
                logic [3:0] e;
                e = exp_brk(t, ea, eb, cb[0], vv[0], vv[1], vals[i], vals[o], vals[d]);
                wr_reg(2'd3, 16'h000F);
                access(vv[0], vals[i], vv[1], 1'b0, 1'b0, vals[o], vals[d], 1'b0);
                check(cb ? "R2 R4 flags" : "R2 R3 flags", brk_flags, e);
                check("R5 brk_req", brk_req, (e != 0));
            end
        end

        // R5: stickiness and partial write-one-to-clear
        wr_reg(2'd2, W'((1 << 4) | (1 << 2) | 2));
        wr_reg(2'd3, 16'h000F);
        access(1'b1, LO, 1'b1, 1'b0, 1'b0, HI, 16'h0, 1'b0);
        check("R5 both pairs", brk_flags, 4'hF);
        check("R5 pulse on", brk_req, 1);
        @(negedge clk);
        check("R5 pulse off", brk_req, 0);
        check("R5 sticky", brk_flags, 4'hF);
        wr_reg(2'd3, 16'h0003);
        check("R5 partial clear", brk_flags, 4'hC);
        wr_reg(2'd3, 16'h000C);
        check("R5 full clear", brk_flags, 4'h0);

        // R6 R7 R8 R9 R10: protection sweep
        for (int t = 0; t < 4; t++)
        for (int p = 0; p < 64; p++) begin
            logic [15:0] addrs [5];
            addrs[0] = 16'h00FF; addrs[1] = LO; addrs[2] = 16'h0150;
            addrs[3] = 16'h01FF; addrs[4] = HI;
            wr_reg(2'd2, W'((p << 8) | (1 << 7) | (3 << 4) | (3 << 2) | t));
            for (int ai = 0; ai < 5; ai++)
            for (int s = 0; s < 2; s++)
            for (int k = 0; k < 5; k++) begin
                bit ef;
                ef = exp_fault(t, p, k, s[0], addrs[ai]);
                access(k == 0, addrs[ai], k == 1, k == 2, k == 3, addrs[ai], LO, s[0]);
                if (t == 3)      check("R9 fault", prot_fault, ef);
                else if (k == 3) check("R8 fault", prot_fault, ef);
                else             check("R6 R7 fault", prot_fault, ef);
                check("R10 no brk", brk_req, 0);
                check("R10 no flags", brk_flags, 0);
            end
        end

        // R11: fault timing
        wr_reg(2'd2, W'((1 << 7) | 1));
        @(negedge clk);
        op_rd = 1'b1; op_addr = 16'h0300;
        #1;
        check("R11 same cycle", prot_fault, 0);
        @(negedge clk);
        op_rd = 1'b0;
        check("R11 next cycle", prot_fault, 1);
        @(negedge clk);
        check("R11 after idle", prot_fault, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule